// File: doc/BRIEF.md
# Fixed-Off-Time Bridge Current Chopper

This block regulates the peak current in one full bridge. A comparator outside the block raises `trip` when the sensed current passes its reference. The block then leaves the ON state and runs a fixed off time before it drives the bridge again. The off time has two phases. In the first, both low sides recirculate the current (slow decay). In the second, a single low side conducts and the current decays faster. After the off time the bridge returns to ON. A blanking window after each return to ON stops switching spikes from retriggering the off time at once.

The controller has three named states:
- `PH_ON`: the bridge drives current in the requested direction.
- `PH_SLOW`: slow decay.
- `PH_FAST`: fast decay.

The transitions are:
- ON→SLOW, taken when `trip` is seen after blanking.
- SLOW→FAST, taken when the slow share expires.
- FAST→ON, taken when the fast share expires.
- Any state→ON, taken on `kill`.

A mapping stage turns the state and the requested direction into a four-switch pattern. A dead-time stage then applies that pattern. It drops switches at once, but it turns a switch on only after a programmable gap has passed since the last switch went off.

A motor with two windings uses two instances, one per phase. Each instance has its own comparator and runs on its own.

Top module: `bridge_chopper`

## Requirements
- R1: While `rst_n` is low, all four gates are low. In the first cycle after reset, if the direction is forward, the ON pattern for forward is driven.
- R2: In ON, once blanking has ended, a high `trip` at a clock edge moves the controller to SLOW on that edge. SLOW always moves to FAST, and FAST always moves back to ON. `trip` is ignored in SLOW and FAST.
- R3: `toff` (T) is captured at the edge that starts the decay. SLOW lasts S = floor(5·T/8) cycles and FAST lasts T−S cycles. A change to `toff` during the decay has no effect on the running decay.
- R4: Forward (`dir_req`=01). ON drives `hs_a` and `ls_b`. SLOW drives `ls_a` and `ls_b`. FAST drives only `ls_a`.
- R5: Reverse (`dir_req`=10). ON drives `ls_a` and `hs_b`. SLOW drives `ls_a` and `ls_b`. FAST drives only `ls_b`.
- R6: With `dir_req` at 00 or 11, all gates are low from the cycle after the value is seen. This holds in every state, even when `trip` pulses.
- R7: A gate that must go off goes off at the next edge. A gate that must go on waits until DT_CYC cycles have passed since the last gate went off. The high and low side of one leg are never on together. Seen at the pins, a decay shows this sequence, in order:
  1. The first low-side-only pattern, for DT_CYC cycles.
  2. The slow pattern, for S−DT_CYC cycles.
  3. The fast pattern, for T−S cycles.
  4. All gates off, for DT_CYC cycles.
  5. The ON pattern.
- R8: On each entry to ON, `blank` (B) is loaded and `trip` is ignored for B cycles. If `trip` is held high, ON lasts B+1 cycles, so the high side stays on for B+1−DT_CYC cycles.
- R9: `kill` forces all gates low in the same cycle, without waiting for a clock edge. It holds the controller in ON with blanking reloaded. After `kill` falls, the ON pattern returns after DT_CYC sampled cycles of all-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kill | input | 1 | Global disable: gates off now, state back to ON |
| trip | input | 1 | Comparator flag: sensed current above reference |
| dir_req | input | 2 | 01 forward, 10 reverse, 00 or 11 disabled |
| toff | input | OFF_W | Total off time in cycles |
| blank | input | BLANK_W | Blanking cycles after each entry to ON |
| hs_a | output | 1 | High-side gate, leg A |
| ls_a | output | 1 | Low-side gate, leg A |
| hs_b | output | 1 | High-side gate, leg B |
| ls_b | output | 1 | Low-side gate, leg B |

## Verification
The bench builds the block with OFF_W=6, BLANK_W=4 and DT_CYC=2. This small setting lets it sweep every off time from 8 to 40 in both directions, and in each sweep both the slow share and the fast share exceed the dead time. The bench measures each gate pattern's run length and compares it with the floor(5T/8) split, with blanking values 2 to 6 under a held `trip`, and with the all-off run after `kill`.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [1:0] {
        PH_ON   = 2'd0,
        PH_SLOW = 2'd1,
        PH_FAST = 2'd2
    } phase_e;

    // pattern bit positions: leg A high/low, leg B high/low
    localparam int G_HS_A = 0;
    localparam int G_LS_A = 1;
    localparam int G_HS_B = 2;
    localparam int G_LS_B = 3;
    localparam int N_GATE = 4;
    localparam int N_LEG  = 2;
endpackage

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_W   = 10,
    parameter int BLANK_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill,
    input  logic               trip,
    input  logic [OFF_W-1:0]   toff,
    input  logic [BLANK_W-1:0] blank,
    output phase_e             phase
);
    phase_e             phase_nx;
    logic [OFF_W-1:0]   rem;
    logic [OFF_W-1:0]   fast_len;
    logic [BLANK_W-1:0] blank_rem;
    logic [OFF_W+2:0]   prod5;
    logic [OFF_W-1:0]   slow_len;
    logic               rem_last;
    logic               blanked;

    assign prod5    = {3'b000, toff} + {1'b0, toff, 2'b00};
    assign slow_len = prod5[OFF_W+2:3];
    assign rem_last = (rem <= OFF_W'(1));
    assign blanked  = (blank_rem != '0);

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_ON:   if (!blanked && trip) phase_nx = PH_SLOW;
            PH_SLOW: if (rem_last) phase_nx = PH_FAST;
            PH_FAST: if (rem_last) phase_nx = PH_ON;
            default: phase_nx = PH_ON;
        endcase
        if (kill) phase_nx = PH_ON;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_ON;
        else        phase <= phase_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem       <= '0;
            fast_len  <= '0;
            blank_rem <= '0;
        end else if (kill) begin
            rem       <= '0;
            blank_rem <= blank;
        end else begin
            unique case (phase)
                PH_ON: begin
                    if (blanked) begin
                        blank_rem <= blank_rem - BLANK_W'(1);
                    end else if (trip) begin
                        rem      <= slow_len;
                        fast_len <= toff - slow_len;
                    end
                end
                PH_SLOW: rem <= rem_last ? fast_len : rem - OFF_W'(1);
                PH_FAST: begin
                    if (rem_last) blank_rem <= blank;
                    else          rem <= rem - OFF_W'(1);
                end
                default: rem <= '0;
            endcase
        end
    end

    // R2
    slow_to_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLOW && !kill) |=> (phase != PH_ON));
    // R2
    fast_not_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FAST && !kill) |=> (phase != PH_SLOW));
    // R8
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ON && blanked && !kill) |=> (phase == PH_ON));
    // R9
    kill_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (phase == PH_ON));
endmodule

// File: rtl/gate_map.sv
module gate_map
    import chop_pkg::*;
(
    input  phase_e            phase,
    input  logic [1:0]        dir_req,
    output logic [N_GATE-1:0] pattern
);
    logic fwd, rev;
    assign fwd = (dir_req == 2'b01);
    assign rev = (dir_req == 2'b10);

    always_comb begin
        pattern = '0;
        unique case (phase)
            PH_ON: begin
                pattern[G_HS_A] = fwd;
                pattern[G_LS_B] = fwd;
                pattern[G_LS_A] = rev;
                pattern[G_HS_B] = rev;
            end
            PH_SLOW: begin
                pattern[G_LS_A] = fwd | rev;
                pattern[G_LS_B] = fwd | rev;
            end
            PH_FAST: begin
                pattern[G_LS_A] = fwd;
                pattern[G_LS_B] = rev;
            end
            default: pattern = '0;
        endcase
    end
endmodule

// File: rtl/dead_time.sv
module dead_time
    import chop_pkg::*;
#(
    parameter int DT_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic [N_GATE-1:0] target,
    output logic [N_GATE-1:0] applied
);
    localparam int CW = $clog2(DT_CYC + 1);
    localparam logic [CW-1:0] DT_LOAD = CW'(DT_CYC - 1);

    logic [CW-1:0] gap;
    logic          drops;

    assign drops = |(applied & ~target);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied <= '0;
            gap     <= '0;
        end else if (kill) begin
            applied <= '0;
            gap     <= DT_LOAD;
        end else if (drops) begin
            applied <= applied & target;
            gap     <= DT_LOAD;
        end else if (gap != '0) begin
            gap <= gap - CW'(1);
        end else begin
            applied <= target;
        end
    end

    for (genvar g = 0; g < N_LEG; g++) begin : g_leg
        // R7
        leg_no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(applied[2*g] && applied[2*g+1]));
    end

    if (DT_CYC >= 2) begin : g_gap
        // R7
        turn_on_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((applied & ~$past(applied)) != '0) |->
            (($past(applied) & ~$past(applied, 2)) == '0 &&
             ($past(applied, 2) & ~$past(applied)) == '0));
    end
endmodule

// File: rtl/bridge_chopper.sv
module bridge_chopper
    import chop_pkg::*;
#(
    parameter int OFF_W   = 10,
    parameter int BLANK_W = 6,
    parameter int DT_CYC  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill,
    input  logic               trip,
    input  logic [1:0]         dir_req,
    input  logic [OFF_W-1:0]   toff,
    input  logic [BLANK_W-1:0] blank,
    output logic               hs_a,
    output logic               ls_a,
    output logic               hs_b,
    output logic               ls_b
);
    phase_e            phase;
    logic [N_GATE-1:0] target;
    logic [N_GATE-1:0] applied;
    logic [N_GATE-1:0] gates;
    logic              dir_off;

    chop_fsm #(.OFF_W(OFF_W), .BLANK_W(BLANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .kill(kill), .trip(trip),
        .toff(toff), .blank(blank), .phase(phase)
    );

    gate_map u_map (.phase(phase), .dir_req(dir_req), .pattern(target));

    dead_time #(.DT_CYC(DT_CYC)) u_dt (
        .clk(clk), .rst_n(rst_n), .kill(kill),
        .target(target), .applied(applied)
    );

    assign gates = applied & ~{N_GATE{kill}};
    assign hs_a  = gates[G_HS_A];
    assign ls_a  = gates[G_LS_A];
    assign hs_b  = gates[G_HS_B];
    assign ls_b  = gates[G_LS_B];

    assign dir_off = (dir_req == 2'b00) || (dir_req == 2'b11);

    // R6
    dir_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_off |=> (!dir_off || gates == '0));
endmodule

// File: tb/bridge_chopper_bench.sv
module bridge_chopper_bench;
    localparam int OFF_W = 6;
    localparam int BLANK_W = 4;
    localparam int DT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kill = 1'b0;
    logic trip = 1'b0;
    logic [1:0] dir_req = 2'b01;
    logic [OFF_W-1:0] toff = 6'd16;
    logic [BLANK_W-1:0] blank = 4'd3;
    logic hs_a, ls_a, hs_b, ls_b;
    logic [3:0] gates;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bridge_chopper #(.OFF_W(OFF_W), .BLANK_W(BLANK_W), .DT_CYC(DT)) u_bridge_chopper (
        .clk(clk), .rst_n(rst_n), .kill(kill), .trip(trip), .dir_req(dir_req),
        .toff(toff), .blank(blank),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    assign gates = {ls_b, hs_b, ls_a, hs_a};

    task automatic check_val(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_run(input logic [3:0] pat, input int len, input string tag);
        int n;
        n = 0;
        check_val({tag, " pattern"}, int'(gates), int'(pat));
        while (gates == pat && n < 2000) begin
            n++;
            @(negedge clk);
        end
        check_val({tag, " run length"}, n, len);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_trip();
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
    endtask

    task automatic skip_on(input logic [3:0] onp);
        int n;
        n = 0;
        while (gates == onp && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic decay_seq(input bit fwd, input int t, input string tag);
        int s, f;
        logic [3:0] onp, off1, fastp;
        s = (5 * t) / 8;
        f = t - s;
        onp   = fwd ? 4'b1001 : 4'b0110;
        off1  = fwd ? 4'b1000 : 4'b0010;
        fastp = fwd ? 4'b0010 : 4'b1000;
        skip_on(onp);
        expect_run(off1, DT, {tag, " R7 opening gap"});
        expect_run(4'b1010, s - DT, {tag, " R3 slow share"});
        expect_run(fastp, f, {tag, " R3 fast share"});
        expect_run(4'b0000, DT, {tag, " R7 closing gap"});
        check_val({tag, " R2 back to ON"}, int'(gates), int'(onp));
    endtask

    initial begin
        // R1 reset state
        idle(3);
        check_val("R1 gates low in reset", int'(gates), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 forward ON after reset", int'(gates), 4'b1001);
        idle(8);

        // R2 R3 R4 forward sweep
        for (int t = 8; t <= 40; t++) begin
            toff = OFF_W'(t);
            idle(8);
            pulse_trip();
            decay_seq(1'b1, t, "R4 fwd");
        end

        // R5 reverse sweep
        dir_req = 2'b10;
        idle(10);
        check_val("R5 reverse ON pattern", int'(gates), 4'b0110);
        for (int t = 8; t <= 40; t++) begin
            toff = OFF_W'(t);
            idle(8);
            pulse_trip();
            decay_seq(1'b0, t, "R5 rev");
        end

        // R3 capture of toff at trip
        dir_req = 2'b01;
        toff = 6'd16;
        idle(10);
        pulse_trip();
        toff = 6'd40;
        decay_seq(1'b1, 16, "R3 captured toff");

        // R8 blanking with trip held
        toff = 6'd16;
        for (int b = 2; b <= 6; b++) begin
            blank = BLANK_W'(b);
            idle(10);
            trip = 1'b1;
            decay_seq(1'b1, 16, "R8 held trip");
            expect_run(4'b1001, b + 1 - DT, "R8 ON length under held trip");
            trip = 1'b0;
            check_val("R8 next decay starts", int'(gates), 4'b1000);
            idle(40);
        end
        blank = 4'd3;

        // R9 kill during slow decay
        idle(10);
        pulse_trip();
        skip_on(4'b1001);
        idle(DT + 1);
        check_val("R9 in slow before kill", int'(gates), 4'b1010);
        kill = 1'b1;
        #1;
        check_val("R9 gates off at once", int'(gates), 0);
        idle(5);
        check_val("R9 gates stay off", int'(gates), 0);
        kill = 1'b0;
        #1;
        expect_run(4'b0000, DT, "R9 off run after release");
        check_val("R9 resumes ON pattern", int'(gates), 4'b1001);
        idle(10);

        // R6 disabled directions
        for (int d = 0; d < 2; d++) begin
            int bad;
            dir_req = (d == 0) ? 2'b00 : 2'b11;
            idle(3);
            check_val("R6 disabled gates low", int'(gates), 0);
            bad = 0;
            trip = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (i == 2) trip = 1'b0;
                if (gates != 4'b0000) bad++;
            end
            check_val("R6 disabled through trip", bad, 0);
        end
        dir_req = 2'b01;
        idle(DT + 3);
        check_val("R6 forward restored", int'(gates), 4'b1001);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule